// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital controller for a four-channel acquisition front end. All channels share one successive-approximation converter. A rising edge on the start input freezes every track/hold at once; the digital model of this is a snapshot of the analog input codes. The controller then converts the programmed channels one after another. It writes each 14-bit result into a small result memory. When the final channel is done, it pulls the active-low interrupt low and puts the track/holds back into tracking.

Software reads the results through a chip-select and read-strobe pair. The read pointer always starts at channel 1 and steps one word per strobe. It wraps after the last programmed channel, so there is no random access. The converter is a behavioural stub that returns the held code after a fixed conversion time. Conversion time (3 µs) and minimum acquisition time (1 µs) are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `simsamp_seq`

## Requirements
- R1: After reset, hold_o is 0, irq_no is 1, data_o is 0, every stored word is 0, and the channel count is four.
- R2: A rising edge on start_i that is accepted captures all channel inputs of ain_i (channel k in bits [14k+13:14k]) in that same clock. hold_o reads 1 from the next cycle. The stored results equal those captured values, whatever ain_i does afterwards.
- R3: Each channel takes CONV_CYC = 3·CLK_HZ/1e6 clock cycles. With N channels, hold_o and irq_no both change exactly N·CONV_CYC cycles after the accepting edge.
- R4: Rising edges of start_i while hold_o is 1 are ignored. They neither restart the sequence nor move its end.
- R5: At the end of the final conversion, irq_no goes low and hold_o goes low (tracking).
- R6: A read is a clock in which cs_ni is 0 and rd_ni has just fallen (rd_ni is 0 now and was 1 in the previous clock). On the following clock edge, data_o takes the word at the read pointer. The first read after an accepted start returns channel 1.
- R7: The read pointer advances once per read. After the last programmed channel it returns to channel 1, so further reads cycle through the words again.
- R8: cs_ni may stay low across any number of reads. A falling rd_ni while cs_ni is 1 changes neither data_o nor the pointer.
- R9: After the return to tracking, a start edge is honoured only once ACQ_CYC = CLK_HZ/1e6 cycles have passed. Earlier edges are dropped.
- R10: cfg_we_i writes cfg_cnt_i, where value v selects v+1 channels. A write returns the read pointer to channel 1. A sequence already running keeps the count that was in force when it was accepted.
- R11: irq_no returns to 1 on the first read after it went low, or on an accepted start.
- R12: When a read and the end of the final conversion fall in the same clock, irq_no still goes low. The read returns the memory contents from before that clock's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-convert; rising edge requests a sample |
| ain_i | input | 56 | Analog input levels as codes, 14 bits per channel |
| cfg_we_i | input | 1 | Write strobe for channel count |
| cfg_cnt_i | input | 2 | Channel count minus one |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low, falling edge reads |
| hold_o | output | 1 | Track/holds in hold |
| irq_no | output | 1 | End-of-sequence interrupt, active low |
| data_o | output | 14 | Last word read |

## Verification
Two events can land on the same clock edge: the end of the final conversion, which writes memory and lowers the interrupt, and a read strobe, which raises the interrupt and reads memory. The bench provokes this with a one-channel sequence, dropping rd_ni so that the strobe is seen on exactly the edge where the conversion finishes. It then judges that irq_no is low, that data_o holds the word stored before that edge, and that the next read returns the new result. A second overlap, a start edge arriving mid-conversion, is judged by the unchanged end time.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  typedef enum logic [0:0] {ST_TRACK, ST_CONV} seq_state_e;

  function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/simsamp_conv_stub.sv
module simsamp_conv_stub #(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned CONV_CYC = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              done_o,
  output logic [DATA_W-1:0] code_o
);
  localparam int unsigned CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  logic [DATA_W-1:0] code_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      code_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CW'(CONV_CYC - 1);
      busy_q <= 1'b1;
      code_q <= val_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_START_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_q || done_o)); // R3

endmodule

// File: rtl/simsamp_result_mem.sv
module simsamp_result_mem #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 14,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              ptr_clr_i,
  input  logic [CH_W-1:0]   last_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] mem_q [NUM_CH];
  logic [CH_W-1:0]   ptr_q;
  logic [DATA_W-1:0] data_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == CH_W'(g))        mem_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      if (rd_i) data_q <= mem_q[ptr_q];
      if (ptr_clr_i)   ptr_q <= '0;
      else if (rd_i)   ptr_q <= (ptr_q >= last_i) ? '0 : ptr_q + 1'b1;
    end
  end

  assign data_o = data_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= last_i || $past(last_i) != last_i); // R7
  AST_PTR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> ptr_q == '0); // R10
  AST_NO_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_q)); // R8

endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
  import simsamp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 10_000_000,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 14,
  localparam int unsigned CH_W     = $clog2(NUM_CH),
  localparam int unsigned CONV_CYC = us_to_cycles(CLK_HZ, 3),
  localparam int unsigned ACQ_CYC  = us_to_cycles(CLK_HZ, 1),
  localparam int unsigned AW       = $clog2(ACQ_CYC + 1) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_CH*DATA_W-1:0] ain_i,
  input  logic                     cfg_we_i,
  input  logic [CH_W-1:0]          cfg_cnt_i,
  input  logic                     cs_ni,
  input  logic                     rd_ni,
  output logic                     hold_o,
  output logic                     irq_no,
  output logic [DATA_W-1:0]        data_o
);
  seq_state_e               state_q;
  logic [CH_W-1:0]          ch_q, seq_last_q, cfg_last_q;
  logic [NUM_CH*DATA_W-1:0] held_q;
  logic [AW-1:0]            acq_cnt_q;
  logic                     start_q, rd_q, hold_q, irq_q;

  logic                     acq_ok, accept, conv_done, last_done, next_start;
  logic                     stub_start, rd_pulse;
  logic [CH_W-1:0]          ch_next;
  logic [DATA_W-1:0]        stub_val, stub_code;

  assign acq_ok     = (acq_cnt_q >= AW'(ACQ_CYC));
  assign accept     = (state_q == ST_TRACK) && acq_ok && start_i && !start_q;
  assign last_done  = (state_q == ST_CONV) && conv_done && (ch_q == seq_last_q);
  assign next_start = (state_q == ST_CONV) && conv_done && (ch_q != seq_last_q);
  assign stub_start = accept || next_start;
  assign ch_next    = ch_q + 1'b1;
  assign stub_val   = accept ? ain_i[DATA_W-1:0] : held_q[ch_next*DATA_W +: DATA_W];
  assign rd_pulse   = !cs_ni && rd_q && !rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      rd_q    <= 1'b1;
    end else begin
      start_q <= start_i;
      rd_q    <= rd_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cfg_last_q <= CH_W'(NUM_CH - 1);
    else if (cfg_we_i)
      cfg_last_q <= (cfg_cnt_i > CH_W'(NUM_CH - 1)) ? CH_W'(NUM_CH - 1) : cfg_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_TRACK;
      ch_q       <= '0;
      seq_last_q <= '0;
      hold_q     <= 1'b0;
    end else if (accept) begin
      state_q    <= ST_CONV;
      ch_q       <= '0;
      seq_last_q <= cfg_last_q;
      hold_q     <= 1'b1;
    end else if (last_done) begin
      state_q    <= ST_TRACK;
      hold_q     <= 1'b0;
    end else if (next_start) begin
      ch_q       <= ch_next;
    end
  end

  // simultaneous capture of every channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_th
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     held_q[g*DATA_W +: DATA_W] <= '0;
      else if (accept) held_q[g*DATA_W +: DATA_W] <= ain_i[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              acq_cnt_q <= '0;
    else if (accept || state_q == ST_CONV)    acq_cnt_q <= '0;
    else if (!acq_ok)                         acq_cnt_q <= acq_cnt_q + 1'b1;
  end

  // end of sequence outranks read and start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_q <= 1'b1;
    else if (last_done)            irq_q <= 1'b0;
    else if (accept || rd_pulse)   irq_q <= 1'b1;
  end

  simsamp_conv_stub #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_stub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stub_start),
    .val_i   (stub_val),
    .done_o  (conv_done),
    .code_o  (stub_code)
  );

  simsamp_result_mem #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   ((state_q == ST_CONV) && conv_done),
    .wr_addr_i (ch_q),
    .wr_data_i (stub_code),
    .rd_i      (rd_pulse),
    .ptr_clr_i (accept || cfg_we_i),
    .last_i    (cfg_last_q),
    .data_o    (data_o)
  );

  assign hold_o = hold_q;
  assign irq_no = irq_q;

  // checker-side count of tracking cycles
  logic [AW-1:0] track_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            track_len_q <= '0;
    else if (hold_q)                        track_len_q <= '0;
    else if (track_len_q < AW'(ACQ_CYC))    track_len_q <= track_len_q + 1'b1;
  end

  AST_ACQ_BEFORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(track_len_q) == AW'(ACQ_CYC)); // R9
  AST_IRQ_ONLY_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q |-> !hold_q); // R5
  AST_HELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && $past(hold_q)) |-> $stable(held_q)); // R2
  AST_RESTART_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && start_i && !start_q) |=> $stable(held_q)); // R4
  AST_END_LOWERS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> !irq_q); // R12

endmodule

// File: tb/simsamp_seq_bench.sv
module simsamp_seq_bench;
  localparam int CLK_HZ     = 10_000_000;
  localparam int NCH        = 4;
  localparam int DW         = 14;
  localparam int CONV       = 3 * (CLK_HZ / 1_000_000);
  localparam int ACQ        = CLK_HZ / 1_000_000;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, cfg_we, cs_n, rd_n;
  logic [1:0]        cfg_cnt;
  logic [NCH*DW-1:0] ain;
  logic              hold, irq_n;
  logic [DW-1:0]     data;

  simsamp_seq #(.CLK_HZ(CLK_HZ), .NUM_CH(NCH), .DATA_W(DW)) u_simsamp_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ain_i(ain),
    .cfg_we_i(cfg_we), .cfg_cnt_i(cfg_cnt), .cs_ni(cs_n), .rd_ni(rd_n),
    .hold_o(hold), .irq_no(irq_n), .data_o(data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] ref_mem [NCH];
  logic [DW-1:0] ref_new [NCH];
  logic [DW-1:0] ref_data;
  int ref_n, seq_n, ref_ptr;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] word_of(logic [NCH*DW-1:0] v, int i);
    return v[i*DW +: DW];
  endfunction

  function automatic int next_ptr(int p, int n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rand_ain;
    ain = (NCH*DW)'({$urandom(), $urandom()});
  endtask

  task automatic write_cfg(int v);
    cfg_we = 1'b1; cfg_cnt = 2'(v); tick; cfg_we = 1'b0;
    ref_n = v + 1; ref_ptr = 0;
  endtask

  task automatic start_seq;
    repeat (ACQ) tick;
    for (int i = 0; i < NCH; i++) ref_new[i] = word_of(ain, i);
    start = 1'b1; tick; start = 1'b0;
    seq_n = ref_n; ref_ptr = 0;
    chk("R2 hold after accept", 32'(hold), 32'd1);
    chk("R11 irq high after accept", 32'(irq_n), 32'd1);
  endtask

  task automatic finish_seq(bit poke, int elapsed);
    int total = seq_n * CONV - 1 - elapsed;
    for (int i = 0; i < total; i++) begin
      if (poke && i == 3) start = 1'b1;
      if (poke && i == 5) start = 1'b0;
      tick;
    end
    start = 1'b0;
    chk("R3 R4 still holding", 32'(hold), 32'd1);
    chk("R3 irq not yet", 32'(irq_n), 32'd1);
    tick;
    chk("R5 back to track", 32'(hold), 32'd0);
    chk("R5 irq low", 32'(irq_n), 32'd0);
    for (int i = 0; i < NCH; i++) if (i < seq_n) ref_mem[i] = ref_new[i];
  endtask

  task automatic do_read(bit cs_high);
    cs_n = cs_high; rd_n = 1'b0; tick;
    if (!cs_high) begin
      ref_data = ref_mem[ref_ptr];
      ref_ptr  = next_ptr(ref_ptr, ref_n);
      chk("R6 R7 read word", 32'(data), 32'(ref_data));
      chk("R11 irq after read", 32'(irq_n), 32'd1);
    end else begin
      chk("R8 deselected read ignored", 32'(data), 32'(ref_data));
    end
    rd_n = 1'b1; tick;
    cs_n = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] old;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; cfg_we = 1'b0; cfg_cnt = '0;
    cs_n = 1'b0; rd_n = 1'b1; ain = '0;
    for (int i = 0; i < NCH; i++) ref_mem[i] = '0;
    ref_data = '0; ref_n = NCH; ref_ptr = 0;
    repeat (3) @(negedge clk);
    chk("R1 hold reset", 32'(hold), 32'd0);
    chk("R1 irq reset", 32'(irq_n), 32'd1);
    chk("R1 data reset", 32'(data), 32'd0);
    rst_n = 1'b1;
    tick;
    do_read(1'b0);  // R1 stored words zero

    // R2 R3 R4: full sequence, inputs change mid-run, stray start edge
    rand_ain; start_seq; rand_ain;
    finish_seq(1'b1, 0);
    for (int i = 0; i < 6; i++) do_read(1'b0);  // R7 wraps after four
    do_read(1'b1); do_read(1'b0);               // R8

    // R9: early start dropped
    start_seq; finish_seq(1'b0, 0);
    start = 1'b1; tick; start = 1'b0; tick;
    chk("R9 early start dropped", 32'(hold), 32'd0);
    chk("R9 irq untouched", 32'(irq_n), 32'd0);

    // R10: count write resets pointer; running sequence keeps its count
    do_read(1'b0);
    write_cfg(1);
    do_read(1'b0); do_read(1'b0); do_read(1'b0);
    rand_ain; start_seq;
    write_cfg(3);
    finish_seq(1'b0, 1);
    do_read(1'b0); do_read(1'b0); do_read(1'b0);

    // R12: read strobe lands on final conversion edge
    write_cfg(0);
    rand_ain; start_seq;
    old = ref_mem[0];
    repeat (CONV - 1) tick;
    cs_n = 1'b0; rd_n = 1'b0; tick;
    chk("R12 irq low despite read", 32'(irq_n), 32'd0);
    chk("R12 hold low", 32'(hold), 32'd0);
    chk("R12 pre-write word", 32'(data), 32'(old));
    ref_data = old; ref_mem[0] = ref_new[0];
    rd_n = 1'b1; tick;
    do_read(1'b0);

    // random sequences
    for (int it = 0; it < 40; it++) begin
      write_cfg($urandom() % 4);
      rand_ain; start_seq; rand_ain;
      finish_seq(bit'($urandom() % 2), 0);
      for (int r = 0; r < 1 + int'($urandom() % 6); r++)
        do_read(($urandom() % 5) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule